// File: doc/BRIEF.md
# Four-Lane Serial ADC Frame Capture

This block fetches one complete set of conversion results from an eight-channel converter whose serial port has four data-out lines. A single-cycle `trigger` pulse (produced elsewhere from the falling edge of the converter's busy flag) starts a read. The block pulls chip select low, toggles a serial clock derived from the system clock, and shifts all four lanes in together on each rising serial-clock edge. Each lane carries two channel words back to back, so after 32 serial clocks the eight 16-bit channel results are complete.

Every finished frame is delivered on two outputs at once. The first is a 128-bit packed word with one-cycle `adc_valid` and `adc_sync` strobes for a FIFO. The second is eight separate per-channel buses with their own one-cycle `chan_valid` strobe for a packing stage. Each channel word is sign-extended from the converter resolution to the output width.

The controller is a four-state machine. `ST_IDLE` waits with chip select high. The `start` transition (trigger seen in `ST_IDLE`) enters `ST_LOW`, the low half of a serial clock period. The `rise` transition (phase timer expired) enters `ST_HIGH` and samples the lanes. From `ST_HIGH` the `next_bit` transition goes back to `ST_LOW`, and the `last_bit` transition (32nd bit) goes to `ST_DONE`. `ST_DONE` raises chip select, loads the output registers, and returns to `ST_IDLE` through the `publish` transition.

Top module: `qlane_capture`

## Requirements
- R1: After reset `cs_n` is 1, `sclk` is 0, and `adc_valid`, `adc_sync` and `chan_valid` are 0.
- R2: A trigger seen while idle drives `cs_n` low from the next clock edge. It stays low for exactly 64*HALF_DIV clock cycles, and `sclk` makes exactly 32 rising edges inside that window. Each half of a serial clock period lasts HALF_DIV system clocks.
- R3: `sclk` is 0 whenever `cs_n` is 1.
- R4: Lane inputs are sampled at each rising `sclk` edge, most significant bit first. Lane k (sdi[k]) delivers the 16 bits of channel k first, then the 16 bits of channel k+4.
- R5: In the packed word, channel c occupies bits [16c+15:16c], so channel 0 is in bits [15:0].
- R6: `adc_valid` and `adc_sync` are high together for exactly one clock cycle per frame. That cycle starts at the edge one cycle after `cs_n` returns high, which is 64*HALF_DIV+1 edges after the trigger edge.
- R7: `chan_data[c]` equals channel c's word, and `chan_valid` is high in exactly the same cycle as `adc_valid`.
- R8: A trigger arriving while a read is in progress is ignored. The current frame's timing and data are unchanged, and no extra frame follows.
- R9: A trigger during the cycle that `adc_valid` is high starts a new read, and `cs_n` falls at the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| trigger | input | 1 | One-cycle start-of-read pulse |
| cs_n | output | 1 | Active-low chip select to the converter |
| sclk | output | 1 | Serial clock to the converter |
| sdi | input | NUM_LANES (4) | Serial data-in lanes |
| adc_data | output | NUM_CH*OUT_W (128) | Packed frame, channel 0 in the low bits |
| adc_valid | output | 1 | Packed frame valid, one cycle |
| adc_sync | output | 1 | Frame sync for the FIFO, one cycle with valid |
| chan_data | output | NUM_CH x OUT_W (8x16) | Per-channel words |
| chan_valid | output | 1 | Per-channel bus valid, one cycle |

## Verification
Results are due at fixed cycle counts after the edge that accepts a trigger. Chip select is low from edge 1 through edge 64*HALF_DIV, and the strobes and data appear after edge 64*HALF_DIV+1. The bench counts negative clock edges from the trigger edge and samples each output only at its exact due count, so early or late outputs are reported. The converter model changes each lane bit after every falling `sclk` edge, which keeps data stable across the design's sampling edge. A mid-read trigger and a trigger in the valid cycle are placed at known counts, and the results are checked against the same schedule.

// File: rtl/qlane_pkg.sv
package qlane_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_LOW  = 2'd1,
        ST_HIGH = 2'd2,
        ST_DONE = 2'd3
    } cap_state_t;
endpackage

// File: rtl/qlane_phase_timer.sv
module qlane_phase_timer #(
    parameter int HALF_DIV = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart,
    output logic expire
);
    localparam int CNT_W = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;

    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (restart) begin
            cnt <= CNT_W'(HALF_DIV - 1);
        end else if (cnt != '0) begin
            cnt <= cnt - 1'b1;
        end
    end

    assign expire = (cnt == '0);
endmodule

// File: rtl/qlane_lane_shifter.sv
module qlane_lane_shifter #(
    parameter int BITS = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            clear,
    input  logic            shift_en,
    input  logic            din,
    output logic [BITS-1:0] q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else if (clear) begin
            q <= '0;
        end else if (shift_en) begin
            q <= {q[BITS-2:0], din};
        end
    end
endmodule

// File: rtl/qlane_frame_pack.sv
module qlane_frame_pack #(
    parameter int NUM_LANES   = 4,
    parameter int CH_PER_LANE = 2,
    parameter int RES         = 16,
    parameter int OUT_W       = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    input  logic [NUM_LANES-1:0][CH_PER_LANE*RES-1:0] lane_words,
    output logic [NUM_LANES*CH_PER_LANE*OUT_W-1:0]    packed_word,
    output logic [NUM_LANES*CH_PER_LANE-1:0][OUT_W-1:0] chan_words,
    output logic fifo_valid,
    output logic fifo_sync,
    output logic pp_valid
);
    localparam int NUM_CH    = NUM_LANES * CH_PER_LANE;
    localparam int LANE_BITS = CH_PER_LANE * RES;

    logic [NUM_CH-1:0][OUT_W-1:0] ext;

    for (genvar k = 0; k < NUM_LANES; k++) begin : g_lane
        for (genvar j = 0; j < CH_PER_LANE; j++) begin : g_slot
            localparam int CH  = j * NUM_LANES + k;
            localparam int TOP = LANE_BITS - 1 - j * RES;
            logic [RES-1:0] raw;
            assign raw = lane_words[k][TOP -: RES];
            if (OUT_W > RES) begin : g_ext
                assign ext[CH] = {{(OUT_W-RES){raw[RES-1]}}, raw};
            end else begin : g_same
                assign ext[CH] = raw[OUT_W-1:0];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chan_words <= '0;
            packed_word <= '0;
            fifo_valid <= 1'b0;
            fifo_sync  <= 1'b0;
            pp_valid   <= 1'b0;
        end else begin
            fifo_valid <= load;
            fifo_sync  <= load;
            pp_valid   <= load;
            if (load) begin
                chan_words  <= ext;
                packed_word <= ext;
            end
        end
    end
endmodule

// File: rtl/qlane_capture.sv
module qlane_capture #(
    parameter int NUM_LANES   = 4,
    parameter int CH_PER_LANE = 2,
    parameter int RES         = 16,
    parameter int OUT_W       = 16,
    parameter int HALF_DIV    = 2,
    parameter int NUM_CH      = NUM_LANES * CH_PER_LANE
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         trigger,
    output logic                         cs_n,
    output logic                         sclk,
    input  logic [NUM_LANES-1:0]         sdi,
    output logic [NUM_CH*OUT_W-1:0]      adc_data,
    output logic                         adc_valid,
    output logic                         adc_sync,
    output logic [NUM_CH-1:0][OUT_W-1:0] chan_data,
    output logic                         chan_valid
);
    import qlane_pkg::*;

    localparam int LANE_BITS = CH_PER_LANE * RES;
    localparam int BIT_W     = $clog2(LANE_BITS);

    cap_state_t state, state_nxt;
    logic [BIT_W-1:0] bit_cnt;
    logic phase_end, last_bit, shift_en, clear_lanes, load_out;
    logic [NUM_LANES-1:0][LANE_BITS-1:0] lane_words;

    assign last_bit    = (bit_cnt == BIT_W'(LANE_BITS - 1));
    assign shift_en    = (state == ST_LOW) && phase_end;
    assign clear_lanes = (state == ST_IDLE) && trigger;
    assign load_out    = (state == ST_DONE);

    always_comb begin
        state_nxt = state;
        unique case (state)
            ST_IDLE: if (trigger)   state_nxt = ST_LOW;
            ST_LOW:  if (phase_end) state_nxt = ST_HIGH;
            ST_HIGH: if (phase_end) state_nxt = last_bit ? ST_DONE : ST_LOW;
            ST_DONE: state_nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            bit_cnt <= '0;
        end else begin
            state <= state_nxt;
            if (clear_lanes) begin
                bit_cnt <= '0;
            end else if ((state == ST_HIGH) && phase_end && !last_bit) begin
                bit_cnt <= bit_cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cs_n <= 1'b1;
            sclk <= 1'b0;
        end else begin
            cs_n <= !((state_nxt == ST_LOW) || (state_nxt == ST_HIGH));
            sclk <= (state_nxt == ST_HIGH);
        end
    end

    qlane_phase_timer #(.HALF_DIV(HALF_DIV)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (state_nxt != state),
        .expire  (phase_end)
    );

    for (genvar k = 0; k < NUM_LANES; k++) begin : g_shift
        qlane_lane_shifter #(.BITS(LANE_BITS)) u_lane (
            .clk      (clk),
            .rst_n    (rst_n),
            .clear    (clear_lanes),
            .shift_en (shift_en),
            .din      (sdi[k]),
            .q        (lane_words[k])
        );
    end

    qlane_frame_pack #(
        .NUM_LANES   (NUM_LANES),
        .CH_PER_LANE (CH_PER_LANE),
        .RES         (RES),
        .OUT_W       (OUT_W)
    ) u_pack (
        .clk         (clk),
        .rst_n       (rst_n),
        .load        (load_out),
        .lane_words  (lane_words),
        .packed_word (adc_data),
        .chan_words  (chan_data),
        .fifo_valid  (adc_valid),
        .fifo_sync   (adc_sync),
        .pp_valid    (chan_valid)
    );
endmodule

// File: rtl/qlane_capture_chk.sv
module qlane_capture_chk #(
    parameter int OUT_W  = 16,
    parameter int NUM_CH = 8
) (
    input logic                         clk,
    input logic                         rst_n,
    input logic                         cs_n,
    input logic                         sclk,
    input logic [NUM_CH*OUT_W-1:0]      adc_data,
    input logic                         adc_valid,
    input logic                         adc_sync,
    input logic [NUM_CH-1:0][OUT_W-1:0] chan_data,
    input logic                         chan_valid
);
    AST_SCLK_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |-> !sclk) else $error("sclk high while deselected"); // R3

    AST_VALID_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        adc_valid |=> !adc_valid) else $error("valid longer than one cycle"); // R6

    AST_SYNC_WITH_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        adc_sync == adc_valid) else $error("sync differs from valid"); // R6

    AST_PP_WITH_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        chan_valid == adc_valid) else $error("channel strobe differs"); // R7

    AST_CH0_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        adc_valid |-> (chan_data[0] == adc_data[OUT_W-1:0])) else $error("ch0 mismatch"); // R5

    AST_VALID_AFTER_CS: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(adc_valid) |-> (cs_n && $past(cs_n))) else $error("valid while selected"); // R6
endmodule

bind qlane_capture qlane_capture_chk #(.OUT_W(OUT_W), .NUM_CH(NUM_CH)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cs_n       (cs_n),
    .sclk       (sclk),
    .adc_data   (adc_data),
    .adc_valid  (adc_valid),
    .adc_sync   (adc_sync),
    .chan_data  (chan_data),
    .chan_valid (chan_valid)
);

// File: tb/qlane_capture_bench.sv
module qlane_capture_bench;
    localparam int HD    = 2;
    localparam int DONE_K = 64 * HD + 1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic trigger = 1'b0;
    logic cs_n, sclk;
    logic [3:0] sdi;
    logic [127:0] adc_data;
    logic adc_valid, adc_sync, chan_valid;
    logic [7:0][15:0] chan_data;

    logic [7:0][15:0] expv;
    int idx = 0;
    int rises = 0;
    int errors = 0;
    int checks = 0;

    always #5 clk = ~clk;

    qlane_capture #(.HALF_DIV(HD)) u_qlane_capture (
        .clk(clk), .rst_n(rst_n), .trigger(trigger), .cs_n(cs_n), .sclk(sclk),
        .sdi(sdi), .adc_data(adc_data), .adc_valid(adc_valid), .adc_sync(adc_sync),
        .chan_data(chan_data), .chan_valid(chan_valid)
    );

    // converter model: lane k = channel k then channel k+4, MSB first
    for (genvar k = 0; k < 4; k++) begin : g_model
        logic [31:0] bits;
        assign bits   = {expv[k], expv[k+4]};
        assign sdi[k] = (idx < 32) ? bits[31 - idx] : 1'b0;
    end

    initial forever begin
        @(negedge sclk);
        idx = idx + 1;
    end

    initial forever begin
        @(posedge sclk);
        rises = rises + 1;
    end

    task automatic chk(input bit ok, input string req, input logic [127:0] act,
                       input logic [127:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [15:0] pat(input int p, input int c);
        case (p)
            0: return 16'h0000;
            1: return 16'hFFFF;
            2: return 16'h8000;
            3: return 16'h0001;
            4: return 16'h0001 << ((c * 2) % 16);
            default: return 16'((c + 1) * 16'h1357) ^ 16'(p * 16'h0F0F) ^ 16'(c << 12);
        endcase
    endfunction

    // run one frame; mid_trig pulses a trigger during the read,
    // chain starts the next read in the valid cycle, pre skips the own trigger
    task automatic run_frame(input int p, input bit mid_trig, input bit chain, input bit pre);
        bit seen;
        logic [127:0] packed_exp;
        for (int c = 0; c < 8; c++) expv[c] = pat(p, c);
        for (int c = 0; c < 8; c++) packed_exp[16*c +: 16] = expv[c];
        if (!pre) begin
            idx = 0;
            trigger = 1'b1;
            @(negedge clk);
            trigger = 1'b0;
        end
        rises = 0;
        chk(cs_n == 1'b0, "R2 cs_n low after trigger edge", 128'(cs_n), 128'(0));
        seen = 1'b0;
        for (int k = 1; k <= DONE_K; k++) begin
            @(negedge clk);
            if (mid_trig && k == 40) trigger = 1'b1;
            if (mid_trig && k == 41) trigger = 1'b0;
            if (k == DONE_K - 2) chk(cs_n == 1'b0, "R2 cs_n still low", 128'(cs_n), 128'(0));
            if (k == DONE_K - 1) begin
                chk(cs_n == 1'b1, "R2 cs_n high after 64*HALF_DIV", 128'(cs_n), 128'(1));
                chk(rises == 32, "R2 32 sclk rises", 128'(rises), 128'(32));
            end
            if (k < DONE_K && adc_valid) seen = 1'b1;
        end
        chk(!seen, "R6 no early valid", 128'(seen), 128'(0));
        chk(adc_valid && adc_sync, "R6 valid and sync at due cycle",
            128'({adc_valid, adc_sync}), 128'(3));
        chk(chan_valid, "R7 chan_valid with adc_valid", 128'(chan_valid), 128'(1));
        chk(adc_data == packed_exp, "R4 R5 packed word", adc_data, packed_exp);
        for (int c = 0; c < 8; c++)
            chk(chan_data[c] == expv[c], "R7 per-channel word", 128'(chan_data[c]), 128'(expv[c]));
        if (chain) begin
            idx = 0;
            trigger = 1'b1;
            @(negedge clk);
            trigger = 1'b0;
            chk(!adc_valid, "R6 valid one cycle", 128'(adc_valid), 128'(0));
        end else begin
            @(negedge clk);
            chk(!adc_valid && !adc_sync && !chan_valid, "R6 strobes one cycle",
                128'({adc_valid, adc_sync, chan_valid}), 128'(0));
        end
    endtask

    initial begin
        #2000000;
        errors++;
        checks++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        expv = '0;
        repeat (3) @(negedge clk);
        chk(cs_n == 1'b1 && sclk == 1'b0, "R1 reset pins", 128'({cs_n, sclk}), 128'(2));
        chk(!adc_valid && !adc_sync && !chan_valid, "R1 reset strobes",
            128'({adc_valid, adc_sync, chan_valid}), 128'(0));
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        for (int p = 0; p < 8; p++) run_frame(p, 1'b0, 1'b0, 1'b0);
        // R8: trigger mid-read is ignored
        run_frame(9, 1'b1, 1'b0, 1'b0);
        begin
            bit extra = 1'b0;
            for (int k = 0; k < 30; k++) begin
                @(negedge clk);
                if (!cs_n || adc_valid || sclk) extra = 1'b1;
            end
            chk(!extra, "R8 no extra read after ignored trigger", 128'(extra), 128'(0));
        end
        // R9: trigger in the valid cycle starts a new read
        run_frame(10, 1'b0, 1'b1, 1'b0);
        run_frame(10, 1'b0, 1'b0, 1'b1);
        repeat (5) @(negedge clk);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule